// File: doc/BRIEF.md
# Adaptive Supply and Clock-Multiplier Controller

This block closes two nested control loops around a logic domain that runs close to its threshold voltage. The slow loop takes a measurement window lasting a programmed number of reference-clock periods. It counts ring-oscillator edges inside that window and compares the total with a target, using a dead band around the target. The result steps two supply codes, one for the logic rail and one for the clock-distribution rail. The clock rail code is always kept strictly above the logic rail code.

The fast loop works on a much shorter window counted in controller clock cycles. It compares the oscillator edges seen in that window with the present multiplication factor of a digital PLL and moves the factor one step toward the measured speed. Setup-warning flags from critical-path replica monitors can arrive in any cycle. A warning blocks any increase of the factor, and a warning seen anywhere in a fast window turns the decision at the end of that window into a decrease. A sticky status bit records that a warning occurred. Both oscillator inputs are expected to be already synchronised to the controller clock.

Top module: `avfs_ctrl`

## Requirements
- R1: While the reset is active and after it is released, the outputs are logic code 2^VW-2, clock code 2^VW-1, multiplier 0 and sticky flag 0 until the first update.
- R2: The supply codes change only at the end of a voltage window. A window closes on the cfg_vwin-th rising edge of ref_in, and rising edges of ro_in, including one in the closing cycle, are counted over it.
- R3: With count N, target T and margin M, the window end steps the supply codes up if N+M < T, steps them down if N > T+M, and otherwise leaves them unchanged.
- R4: An up step raises the logic code by one unless it is already at or above cfg_vlog_max, and raises the clock code by one unless it is already at or above cfg_vclk_max. A down step lowers each code by one unless it is at or below its minimum.
- R5: After any step, if the clock code would not exceed the logic code, it is set to the logic code plus one in the same update. As a result vclk_code > vlog_code always holds, given vlog_max < 2^VW-2.
- R6: A frequency window lasts cfg_fwin cycles. At its end the rising edges of ro_in counted in it (F) are compared with the multiplier: F above the multiplier steps it up, F below steps it down, and equality holds it.
- R7: If any bit of warn_in is high in any cycle of a frequency window, including the last one, the window end steps the multiplier down and never up. The multiplier never increases in the cycle after a warning.
- R8: The multiplier changes by at most one per cycle, never rises above cfg_mult_max by an up step, never falls below cfg_mult_min by a down step, and never wraps.
- R9: warn_sticky is set in the cycle after any warn_in bit is high and cleared in the cycle after warn_clr is high. When both are high in the same cycle, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ro_in | input | 1 | Ring-oscillator output, synchronised |
| ref_in | input | 1 | Reference clock, synchronised |
| warn_in | input | NMON | Setup-warning flags from replica monitors |
| warn_clr | input | 1 | Clears the sticky warning flag |
| cfg_vwin | input | PW | Reference edges per voltage window |
| cfg_vtarget | input | CW | Target oscillator count per voltage window |
| cfg_vmargin | input | CW | Half-width of the dead band |
| cfg_vlog_min | input | VW | Lower limit of the logic code |
| cfg_vlog_max | input | VW | Upper limit of the logic code |
| cfg_vclk_min | input | VW | Lower limit of the clock code |
| cfg_vclk_max | input | VW | Upper limit of the clock code |
| cfg_fwin | input | FW | Cycles per frequency window |
| cfg_mult_min | input | MW | Lower limit of the multiplier |
| cfg_mult_max | input | MW | Upper limit of the multiplier |
| vlog_code | output | VW | Logic supply code |
| vclk_code | output | VW | Clock supply code |
| pll_mult | output | MW | PLL multiplication factor |
| warn_sticky | output | 1 | Warning seen since last clear |

## Verification
The bench drives the logic code from its reset value down onto its floor and then back up. A design that compared the limits in the wrong direction would wrap or overshoot, and a design that forgot the clock-rail fix-up would let the two codes meet. An oscillator rate inside the dead band must leave the codes frozen for many windows; an off-by-one in the band would make them creep. Warnings held across fast windows must drive the multiplier to its floor even though the measured speed asks for more, and clear and warning are raised together to expose a wrong priority. Lowering the multiplier ceiling while the oscillator is fast shows whether the factor stops at the limit or overshoots.

// File: rtl/avfs_pkg.sv
package avfs_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/avfs_rst_sync.sv
module avfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/avfs_edge_det.sv
module avfs_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] hist_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[i] <= 1'b0;
      else        hist_q[i] <= sig[i];
    end
    assign rise[i] = sig[i] & ~hist_q[i];
  end
endmodule

// File: rtl/avfs_vloop.sv
module avfs_vloop
  import avfs_pkg::*;
#(
  parameter int PW = 16,
  parameter int CW = 16,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ro_rise,
  input  logic          ref_rise,
  input  logic [PW-1:0] cfg_vwin,
  input  logic [CW-1:0] cfg_vtarget,
  input  logic [CW-1:0] cfg_vmargin,
  input  logic [VW-1:0] cfg_vlog_min,
  input  logic [VW-1:0] cfg_vlog_max,
  input  logic [VW-1:0] cfg_vclk_min,
  input  logic [VW-1:0] cfg_vclk_max,
  output logic [VW-1:0] vlog_code,
  output logic [VW-1:0] vclk_code
);
  localparam logic [VW-1:0] VLOG_RST = {{(VW-1){1'b1}}, 1'b0};
  localparam logic [VW-1:0] VCLK_RST = {VW{1'b1}};
  localparam logic [VW-1:0] V_ONE    = VW'(1);
  localparam logic [CW-1:0] C_ONE    = CW'(1);
  localparam logic [CW-1:0] C_FULL   = {CW{1'b1}};
  localparam logic [PW-1:0] P_ONE    = PW'(1);
  localparam logic [PW:0]   PX_ONE   = (PW+1)'(1);

  logic [CW-1:0] cnt_q, cnt_d, cnt_total;
  logic [PW-1:0] ref_q, ref_d;
  logic          win_end;
  logic [CW:0]   low_sum, high_lim;
  step_e         dir;
  logic [VW-1:0] log_step, clk_step, clk_fix;
  logic [VW-1:0] vlog_d, vclk_d;
  logic          code_en;

  // window bookkeeping
  always_comb begin
    cnt_total = (ro_rise && (cnt_q != C_FULL)) ? cnt_q + C_ONE : cnt_q;
    win_end   = ref_rise && (({1'b0, ref_q} + PX_ONE) >= {1'b0, cfg_vwin});
    if (win_end) begin
      cnt_d = '0;
      ref_d = '0;
    end else begin
      cnt_d = cnt_total;
      ref_d = ref_rise ? ref_q + P_ONE : ref_q;
    end
  end

  // dead-band decision
  always_comb begin
    low_sum  = {1'b0, cnt_total} + {1'b0, cfg_vmargin};
    high_lim = {1'b0, cfg_vtarget} + {1'b0, cfg_vmargin};
    if (low_sum < {1'b0, cfg_vtarget})       dir = STEP_UP;
    else if ({1'b0, cnt_total} > high_lim)   dir = STEP_DN;
    else                                     dir = STEP_HOLD;
  end

  // saturating code step with rail ordering fix-up
  always_comb begin
    log_step = vlog_code;
    clk_step = vclk_code;
    unique case (dir)
      STEP_UP: begin
        if (vlog_code < cfg_vlog_max) log_step = vlog_code + V_ONE;
        if (vclk_code < cfg_vclk_max) clk_step = vclk_code + V_ONE;
      end
      STEP_DN: begin
        if (vlog_code > cfg_vlog_min) log_step = vlog_code - V_ONE;
        if (vclk_code > cfg_vclk_min) clk_step = vclk_code - V_ONE;
      end
      default: ;
    endcase
    clk_fix = (clk_step <= log_step) ? log_step + V_ONE : clk_step;
    code_en = win_end && (dir != STEP_HOLD);
    vlog_d  = code_en ? log_step : vlog_code;
    vclk_d  = code_en ? clk_fix  : vclk_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ref_q     <= '0;
      vlog_code <= VLOG_RST;
      vclk_code <= VCLK_RST;
    end else begin
      cnt_q     <= cnt_d;
      ref_q     <= ref_d;
      vlog_code <= vlog_d;
      vclk_code <= vclk_d;
    end
  end
endmodule

// File: rtl/avfs_floop.sv
module avfs_floop
  import avfs_pkg::*;
#(
  parameter int FW = 12,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ro_rise,
  input  logic          warn_any,
  input  logic [FW-1:0] cfg_fwin,
  input  logic [MW-1:0] cfg_mult_min,
  input  logic [MW-1:0] cfg_mult_max,
  output logic [MW-1:0] pll_mult
);
  localparam int XW = ((FW > MW) ? FW : MW) + 1;
  localparam logic [FW-1:0] F_ONE  = FW'(1);
  localparam logic [FW:0]   FX_ONE = (FW+1)'(1);
  localparam logic [MW-1:0] M_ONE  = MW'(1);

  logic [FW-1:0] cyc_q, cyc_d, cnt_q, cnt_d, cnt_total;
  logic          warn_q, warn_d, warn_seen;
  logic          win_end;
  logic [XW-1:0] cnt_x, mult_x;
  step_e         dir;
  logic [MW-1:0] mult_d;

  always_comb begin
    cnt_total = ro_rise ? cnt_q + F_ONE : cnt_q;
    warn_seen = warn_q | warn_any;
    win_end   = ({1'b0, cyc_q} + FX_ONE) >= {1'b0, cfg_fwin};
    cnt_x     = XW'(cnt_total);
    mult_x    = XW'(pll_mult);

    if (warn_seen)            dir = STEP_DN;
    else if (cnt_x > mult_x)  dir = STEP_UP;
    else if (cnt_x < mult_x)  dir = STEP_DN;
    else                      dir = STEP_HOLD;

    if (win_end) begin
      cyc_d  = '0;
      cnt_d  = '0;
      warn_d = 1'b0;
    end else begin
      cyc_d  = cyc_q + F_ONE;
      cnt_d  = cnt_total;
      warn_d = warn_seen;
    end

    mult_d = pll_mult;
    if (win_end) begin
      unique case (dir)
        STEP_UP: if (pll_mult < cfg_mult_max) mult_d = pll_mult + M_ONE;
        STEP_DN: if (pll_mult > cfg_mult_min) mult_d = pll_mult - M_ONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= '0;
      cnt_q    <= '0;
      warn_q   <= 1'b0;
      pll_mult <= '0;
    end else begin
      cyc_q    <= cyc_d;
      cnt_q    <= cnt_d;
      warn_q   <= warn_d;
      pll_mult <= mult_d;
    end
  end
endmodule

// File: rtl/avfs_ctrl.sv
module avfs_ctrl #(
  parameter int NMON = 4,
  parameter int PW   = 16,
  parameter int CW   = 16,
  parameter int FW   = 12,
  parameter int MW   = 8,
  parameter int VW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ro_in,
  input  logic            ref_in,
  input  logic [NMON-1:0] warn_in,
  input  logic            warn_clr,
  input  logic [PW-1:0]   cfg_vwin,
  input  logic [CW-1:0]   cfg_vtarget,
  input  logic [CW-1:0]   cfg_vmargin,
  input  logic [VW-1:0]   cfg_vlog_min,
  input  logic [VW-1:0]   cfg_vlog_max,
  input  logic [VW-1:0]   cfg_vclk_min,
  input  logic [VW-1:0]   cfg_vclk_max,
  input  logic [FW-1:0]   cfg_fwin,
  input  logic [MW-1:0]   cfg_mult_min,
  input  logic [MW-1:0]   cfg_mult_max,
  output logic [VW-1:0]   vlog_code,
  output logic [VW-1:0]   vclk_code,
  output logic [MW-1:0]   pll_mult,
  output logic            warn_sticky
);
  logic       rst_i_n;
  logic [1:0] rise;
  logic       warn_any;
  logic       sticky_d;

  avfs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  avfs_edge_det #(.W(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .sig   ({ref_in, ro_in}),
    .rise  (rise)
  );

  assign warn_any = |warn_in;

  avfs_vloop #(.PW(PW), .CW(CW), .VW(VW)) u_vloop (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .ro_rise      (rise[0]),
    .ref_rise     (rise[1]),
    .cfg_vwin     (cfg_vwin),
    .cfg_vtarget  (cfg_vtarget),
    .cfg_vmargin  (cfg_vmargin),
    .cfg_vlog_min (cfg_vlog_min),
    .cfg_vlog_max (cfg_vlog_max),
    .cfg_vclk_min (cfg_vclk_min),
    .cfg_vclk_max (cfg_vclk_max),
    .vlog_code    (vlog_code),
    .vclk_code    (vclk_code)
  );

  avfs_floop #(.FW(FW), .MW(MW)) u_floop (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .ro_rise      (rise[0]),
    .warn_any     (warn_any),
    .cfg_fwin     (cfg_fwin),
    .cfg_mult_min (cfg_mult_min),
    .cfg_mult_max (cfg_mult_max),
    .pll_mult     (pll_mult)
  );

  always_comb begin
    if (warn_any)      sticky_d = 1'b1;
    else if (warn_clr) sticky_d = 1'b0;
    else               sticky_d = warn_sticky;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) warn_sticky <= 1'b0;
    else          warn_sticky <= sticky_d;
  end
endmodule

// File: rtl/avfs_ctrl_chk.sv
module avfs_ctrl_chk #(
  parameter int NMON = 4,
  parameter int MW   = 8,
  parameter int VW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ref_in,
  input logic [NMON-1:0] warn_in,
  input logic [VW-1:0]   vlog_code,
  input logic [VW-1:0]   vclk_code,
  input logic [MW-1:0]   pll_mult,
  input logic            warn_sticky
);
  localparam logic [VW-1:0] V_ONE = VW'(1);
  localparam logic [MW-1:0] M_ONE = MW'(1);

  // R5: rail ordering
  p_clk_above_logic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vclk_code > vlog_code);

  // R2: supply codes move only right after a reference edge was present
  p_code_on_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vlog_code != $past(vlog_code)) |-> $past(ref_in));

  // R4: single-step logic code
  p_log_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vlog_code == $past(vlog_code)) || (vlog_code == $past(vlog_code) + V_ONE) ||
    (vlog_code == $past(vlog_code) - V_ONE));

  // R8: single-step multiplier
  p_mult_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mult == $past(pll_mult)) || (pll_mult == $past(pll_mult) + M_ONE) ||
    (pll_mult == $past(pll_mult) - M_ONE));

  // R7: a warning never lets the multiplier rise
  p_warn_no_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_in != '0) |=> (pll_mult <= $past(pll_mult)));

  // R9: warning sets the sticky flag
  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_in != '0) |=> warn_sticky);
endmodule

bind avfs_ctrl avfs_ctrl_chk #(.NMON(NMON), .MW(MW), .VW(VW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_in      (ref_in),
  .warn_in     (warn_in),
  .vlog_code   (vlog_code),
  .vclk_code   (vclk_code),
  .pll_mult    (pll_mult),
  .warn_sticky (warn_sticky)
);

// File: tb/sim_avfs_ctrl.sv
`timescale 1ns/1ps
module sim_avfs_ctrl;
  localparam int NMON = 4, PW = 16, CW = 16, FW = 12, MW = 8, VW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ro_in = 1'b0, ref_in = 1'b0;
  logic [NMON-1:0] warn_in = '0;
  logic            warn_clr = 1'b0;
  logic [PW-1:0]   cfg_vwin = 16'd4;
  logic [CW-1:0]   cfg_vtarget = 16'd12, cfg_vmargin = 16'd3;
  logic [VW-1:0]   cfg_vlog_min = 8'd40, cfg_vlog_max = 8'd200;
  logic [VW-1:0]   cfg_vclk_min = 8'd50, cfg_vclk_max = 8'd230;
  logic [FW-1:0]   cfg_fwin = 12'd16;
  logic [MW-1:0]   cfg_mult_min = 8'd2, cfg_mult_max = 8'd12;
  logic [VW-1:0]   vlog_code, vclk_code;
  logic [MW-1:0]   pll_mult;
  logic            warn_sticky;

  always #2.5 clk = ~clk;

  avfs_ctrl #(.NMON(NMON), .PW(PW), .CW(CW), .FW(FW), .MW(MW), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .ro_in(ro_in), .ref_in(ref_in), .warn_in(warn_in),
    .warn_clr(warn_clr), .cfg_vwin(cfg_vwin), .cfg_vtarget(cfg_vtarget),
    .cfg_vmargin(cfg_vmargin), .cfg_vlog_min(cfg_vlog_min), .cfg_vlog_max(cfg_vlog_max),
    .cfg_vclk_min(cfg_vclk_min), .cfg_vclk_max(cfg_vclk_max), .cfg_fwin(cfg_fwin),
    .cfg_mult_min(cfg_mult_min), .cfg_mult_max(cfg_mult_max),
    .vlog_code(vlog_code), .vclk_code(vclk_code), .pll_mult(pll_mult),
    .warn_sticky(warn_sticky));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // stimulus generators: half periods in clock cycles (0 = idle low)
  int ro_half = 1, ro_ctr = 0;
  int ref_half = 5, ref_ctr = 0;
  always @(negedge clk) begin
    if (ro_half == 0) ro_in <= 1'b0;
    else if (ro_ctr + 1 >= ro_half) begin ro_ctr <= 0; ro_in <= ~ro_in; end
    else ro_ctr <= ro_ctr + 1;
    if (ref_ctr + 1 >= ref_half) begin ref_ctr <= 0; ref_in <= ~ref_in; end
    else ref_ctr <= ref_ctr + 1;
  end

  // behavioural reference model
  int m_sync = 0, m_roq = 0, m_refq = 0;
  int m_vcnt = 0, m_vref = 0, m_fcyc = 0, m_fcnt = 0, m_fwarn = 0;
  int m_vlog = 254, m_vclk = 255, m_mult = 0, m_sticky = 0;

  function automatic void m_reset();
    m_roq = 0; m_refq = 0; m_vcnt = 0; m_vref = 0;
    m_fcyc = 0; m_fcnt = 0; m_fwarn = 0;
    m_vlog = 254; m_vclk = 255; m_mult = 0; m_sticky = 0;
  endfunction

  always @(posedge clk) begin
    int roe, refe, wn, tot, w, nl, nc;
    if (!rst_n) begin m_sync = 0; m_reset(); end
    else if (m_sync < 2) begin m_sync++; m_reset(); end
    else begin
      roe  = (ro_in && !m_roq) ? 1 : 0;
      refe = (ref_in && !m_refq) ? 1 : 0;
      m_roq = ro_in; m_refq = ref_in;
      wn = (warn_in != 0) ? 1 : 0;
      // voltage loop
      tot = (roe != 0 && m_vcnt < 65535) ? m_vcnt + 1 : m_vcnt;
      if (refe != 0 && m_vref + 1 >= int'(cfg_vwin)) begin
        nl = m_vlog; nc = m_vclk;
        if (tot + int'(cfg_vmargin) < int'(cfg_vtarget)) begin
          if (m_vlog < int'(cfg_vlog_max)) nl = m_vlog + 1;
          if (m_vclk < int'(cfg_vclk_max)) nc = m_vclk + 1;
          if (nc <= nl) nc = nl + 1;
          m_vlog = nl; m_vclk = nc;
        end else if (tot > int'(cfg_vtarget) + int'(cfg_vmargin)) begin
          if (m_vlog > int'(cfg_vlog_min)) nl = m_vlog - 1;
          if (m_vclk > int'(cfg_vclk_min)) nc = m_vclk - 1;
          if (nc <= nl) nc = nl + 1;
          m_vlog = nl; m_vclk = nc;
        end
        m_vcnt = 0; m_vref = 0;
      end else begin
        m_vcnt = tot;
        m_vref = m_vref + refe;
      end
      // frequency loop
      tot = m_fcnt + roe;
      w = (m_fwarn != 0 || wn != 0) ? 1 : 0;
      if (m_fcyc + 1 >= int'(cfg_fwin)) begin
        if (w != 0 || tot < m_mult) begin
          if (m_mult > int'(cfg_mult_min)) m_mult--;
        end else if (tot > m_mult) begin
          if (m_mult < int'(cfg_mult_max)) m_mult++;
        end
        m_fcyc = 0; m_fcnt = 0; m_fwarn = 0;
      end else begin
        m_fcyc++; m_fcnt = tot; m_fwarn = w;
      end
      if (wn != 0) m_sticky = 1;
      else if (warn_clr) m_sticky = 0;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      chk(int'(vlog_code) == m_vlog, "R2 logic code", int'(vlog_code), m_vlog);
      chk(int'(vclk_code) == m_vclk, "R4 clock code", int'(vclk_code), m_vclk);
      chk(vclk_code > vlog_code, "R5 rail order", int'(vclk_code), int'(vlog_code) + 1);
      chk(int'(pll_mult) == m_mult, "R6 multiplier", int'(pll_mult), m_mult);
      chk(int'(warn_sticky) == m_sticky, "R9 sticky", int'(warn_sticky), m_sticky);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int held;
    cyc(3);
    chk(vlog_code == 8'd254 && vclk_code == 8'd255, "R1 reset codes", int'(vlog_code), 254);
    chk(pll_mult == 0 && warn_sticky == 0, "R1 reset mult", int'(pll_mult), 0);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);
    chk(vlog_code == 8'd254 && pll_mult == 0, "R1 after release", int'(vlog_code), 254);

    // fast oscillator: codes fall to their floors, multiplier climbs to 8
    ro_half = 1;
    cyc(9500);
    chk(vlog_code == 8'd40, "R4 logic floor", int'(vlog_code), 40);
    chk(vclk_code == 8'd50, "R4 clock floor", int'(vclk_code), 50);
    chk(pll_mult == 8'd8, "R6 tracks count", int'(pll_mult), 8);

    // in-band oscillator: codes must freeze
    ro_half = 2;
    cyc(200);
    held = int'(vlog_code);
    cyc(1000);
    chk(int'(vlog_code) == held, "R3 dead band hold", int'(vlog_code), held);
    chk(pll_mult == 8'd4, "R6 lower count", int'(pll_mult), 4);

    // slow oscillator: codes rise, multiplier to its floor
    ro_half = 4;
    cyc(3000);
    chk(vlog_code > 8'd40, "R3 step up", int'(vlog_code), 41);
    chk(pll_mult == 8'd2, "R8 mult floor", int'(pll_mult), 2);

    // fast again, then held warning
    ro_half = 1;
    cyc(300);
    chk(pll_mult == 8'd8, "R6 climb again", int'(pll_mult), 8);
    warn_in = 4'b0100;
    cyc(200);
    chk(pll_mult == 8'd2, "R7 warning forces down", int'(pll_mult), 2);
    chk(warn_sticky == 1'b1, "R9 sticky set", int'(warn_sticky), 1);
    warn_in = '0;
    cyc(5);
    warn_clr = 1'b1;
    cyc(1);
    warn_clr = 1'b0;
    cyc(1);
    chk(warn_sticky == 1'b0, "R9 sticky cleared", int'(warn_sticky), 0);
    warn_clr = 1'b1; warn_in = 4'b0001;
    cyc(1);
    warn_clr = 1'b0; warn_in = '0;
    cyc(1);
    chk(warn_sticky == 1'b1, "R9 set beats clear", int'(warn_sticky), 1);

    // lowered ceiling
    cfg_mult_max = 8'd5;
    cyc(300);
    chk(pll_mult == 8'd5, "R8 mult ceiling", int'(pll_mult), 5);
    chk(vclk_code > vlog_code, "R5 final order", int'(vclk_code), int'(vlog_code) + 1);

    finish_run();
  end
endmodule